// File: doc/BRIEF.md
# Multi-Cycle 32-bit Integer Multiplier

This block multiplies two 32-bit integers with one 17-by-17-bit signed multiply-accumulate stage. It reuses that stage over several clock cycles. Each operand is split into 16-bit halves. Every half is widened to 17 bits: sign-extended when it is the upper half of an operand taken as signed, and zero-extended otherwise. The block then adds the partial products into a 34-bit accumulator. Between steps the accumulator is shifted right arithmetically by 16 bits, so that the next partial product lines up at the correct weight. The multiply and the add are written with plain `*` and `+` operators. No adder outside the block is used.

Four operations are supported: the low product word, and the high product word for the signed×signed, signed×unsigned and unsigned×unsigned operand pairs. A low-word request never forms the upper-half×upper-half product, because that term cannot reach the low 32 bits. This is why a low-word request finishes one cycle earlier than a high-word request.

A request is a one-cycle `start_i` pulse with the operation code and both operands. It is taken only while the block is idle. The result is registered and announced by a one-cycle `done_o` pulse.

Top module: `mac_mul32`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o` and `busy_o` are 0 and `result_o` is 0.
- R2: Operation code 0 returns bits 31..0 of the product of `a_i` and `b_i`. The result is the same whether the operands are read as signed or unsigned.
- R3: Operation code 1 returns bits 63..32 of the product with both operands taken as two's-complement signed.
- R4: Operation code 2 returns bits 63..32 of the product with `a_i` taken as signed and `b_i` as unsigned.
- R5: Operation code 3 returns bits 63..32 of the product with both operands taken as unsigned.
- R6: When a start with code 0 is taken at rising edge N, `done_o` is 0 after edge N+1 and is 1 after edge N+2.
- R7: When a start with code 1, 2 or 3 is taken at rising edge N, `done_o` is 0 after edges N+1 and N+2 and is 1 after edge N+3.
- R8: `done_o` is never high in two consecutive cycles.
- R9: `busy_o` is 1 from the edge that takes a start until the edge that raises `done_o`. A `start_i` seen while `busy_o` is 1 is ignored: it changes neither the result, nor the completion cycle, nor produces an extra completion.
- R10: A start presented in the cycle in which `done_o` is 1 is taken. It completes with its own latency.
- R11: `result_o` changes only at the edge that raises `done_o`. Otherwise it holds its value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| op_i | input | 2 | Operation code: 0 low word, 1 high signed×signed, 2 high signed×unsigned, 3 high unsigned×unsigned |
| a_i | input | XLEN | First operand (multiplicand) |
| b_i | input | XLEN | Second operand (multiplier) |
| result_o | output | XLEN | Registered result of the last completed request |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A request is in progress |

## Verification
Two events can fall in the same cycle: a completion, and the acceptance of the next request. A start raised while `done_o` is high must be taken, because the block is already idle then. The bench provokes this by raising `start_i` in the exact cycle it observes `done_o` high. It then expects the second result after the second operation's own full latency, with the first result visible in between. A second collision is a start that arrives one cycle after acceptance. The bench judges it ignored when the first result is correct and arrives on time, and when no extra `done_o` pulse follows.

// File: rtl/mac_mul32_pkg.sv
package mac_mul32_pkg;

    typedef enum logic [1:0] {
        OP_LOW   = 2'd0,
        OP_HI_SS = 2'd1,
        OP_HI_SU = 2'd2,
        OP_HI_UU = 2'd3
    } mul_op_e;

    // State value doubles as partial-product selector:
    // bit 1 picks the high half of A, bit 0 the high half of B.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LH   = 2'd1,
        ST_HL   = 2'd2,
        ST_HH   = 2'd3
    } mul_st_e;

endpackage

// File: rtl/mac_mul32_opsel.sv
module mac_mul32_opsel #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    input  logic              a_hi_i,
    input  logic              b_hi_i,
    input  logic              a_sgn_i,
    input  logic              b_sgn_i,
    output logic [XLEN/2:0]   x_o,
    output logic [XLEN/2:0]   y_o
);
    localparam int H = XLEN / 2;

    always_comb begin
        if (a_hi_i) x_o = {a_sgn_i & a_i[XLEN-1], a_i[XLEN-1:H]};
        else        x_o = {1'b0, a_i[H-1:0]};
        if (b_hi_i) y_o = {b_sgn_i & b_i[XLEN-1], b_i[XLEN-1:H]};
        else        y_o = {1'b0, b_i[H-1:0]};
    end
endmodule

// File: rtl/mac_mul32_mac.sv
module mac_mul32_mac #(
    parameter int MW = 17
) (
    input  logic [MW-1:0]   x_i,
    input  logic [MW-1:0]   y_i,
    input  logic [2*MW-1:0] acc_i,
    output logic [2*MW-1:0] sum_o
);
    logic signed [2*MW-1:0] prod;

    assign prod  = $signed(x_i) * $signed(y_i);
    assign sum_o = prod + $signed(acc_i);
endmodule

// File: rtl/mac_mul32.sv
module mac_mul32
    import mac_mul32_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] result_o,
    output logic            done_o,
    output logic            busy_o
);
    localparam int H  = XLEN / 2;
    localparam int MW = H + 1;
    localparam int AW = 2 * MW;

    typedef struct packed {
        mul_st_e         st;
        mul_op_e         op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [AW-1:0]   acc;
        logic [H-1:0]    lo;
        logic [XLEN-1:0] res;
        logic            done;
    } regs_t;

    regs_t q, d;

    logic [XLEN-1:0] a_src, b_src;
    mul_op_e         op_src;
    logic            a_sgn, b_sgn;
    logic [1:0]      sel;
    logic [MW-1:0]   mx, my;
    logic [AW-1:0]   mac_acc, mac_sum, mac_shift;

    // Operands come straight from the ports in the accepting cycle.
    always_comb begin
        if (q.st == ST_IDLE) begin
            a_src  = a_i;
            b_src  = b_i;
            op_src = mul_op_e'(op_i);
        end else begin
            a_src  = q.a;
            b_src  = q.b;
            op_src = q.op;
        end
        a_sgn   = (op_src == OP_HI_SS) || (op_src == OP_HI_SU);
        b_sgn   = (op_src == OP_HI_SS);
        sel     = q.st;
        mac_acc = (q.st == ST_IDLE) ? '0 : q.acc;
    end

    mac_mul32_opsel #(.XLEN(XLEN)) u_opsel (
        .a_i     (a_src),
        .b_i     (b_src),
        .a_hi_i  (sel[1]),
        .b_hi_i  (sel[0]),
        .a_sgn_i (a_sgn),
        .b_sgn_i (b_sgn),
        .x_o     (mx),
        .y_o     (my)
    );

    mac_mul32_mac #(.MW(MW)) u_mac (
        .x_i   (mx),
        .y_i   (my),
        .acc_i (mac_acc),
        .sum_o (mac_sum)
    );

    assign mac_shift = AW'($signed(mac_sum) >>> H);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.a   = a_i;
                    d.b   = b_i;
                    d.op  = mul_op_e'(op_i);
                    d.lo  = mac_sum[H-1:0];
                    d.acc = mac_shift;
                    d.st  = ST_LH;
                end
            end
            ST_LH: begin
                d.acc = mac_sum;
                d.st  = ST_HL;
            end
            ST_HL: begin
                if (q.op == OP_LOW) begin
                    d.res  = {mac_sum[H-1:0], q.lo};
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.acc = mac_shift;
                    d.st  = ST_HH;
                end
            end
            ST_HH: begin
                d.res  = mac_sum[XLEN-1:0];
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign result_o = q.res;
    assign done_o   = q.done;
    assign busy_o   = (q.st != ST_IDLE);
endmodule

// File: rtl/mac_mul32_chk.sv
module mac_mul32_chk #(
    parameter int XLEN = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            start_i,
    input logic [1:0]      op_i,
    input logic [XLEN-1:0] result_o,
    input logic            done_o,
    input logic            busy_o
);
    assert_low_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && op_i == 2'd0) |-> ##3 done_o);

    assert_high_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && op_i != 2'd0) |-> ##4 done_o);

    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_busy_after_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    assert_done_needs_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(busy_o));

    assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));
endmodule

bind mac_mul32 mac_mul32_chk #(.XLEN(XLEN)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .result_o (result_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
);

// File: tb/mac_mul32_tb.sv
`timescale 1ns/1ps
module mac_mul32_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] a = '0, b = '0;
    logic [31:0] result;
    logic        done, busy;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    mac_mul32 #(.XLEN(32)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .a_i(a), .b_i(b), .result_o(result), .done_o(done), .busy_o(busy)
    );

    function automatic logic [31:0] model(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [63:0] xa, yb, p;
        xa = (o == 2'd1 || o == 2'd2) ? {{32{x[31]}}, x} : {32'b0, x};
        yb = (o == 2'd1) ? {{32{y[31]}}, y} : {32'b0, y};
        p  = xa * yb;
        return (o == 2'd0) ? p[31:0] : p[63:32];
    endfunction

    function automatic string rtag(input logic [1:0] o);
        case (o)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 result", result, 32'd0);
    endtask

    // Starts one request, checks completion cycle, result and pulse width.
    task automatic t_op(input logic [1:0] o, input logic [31:0] x, input logic [31:0] y);
        int lat = (o == 2'd0) ? 2 : 3;
        string lt = (o == 2'd0) ? "R6" : "R7";
        @(negedge clk); op = o; a = x; b = y; start = 1'b1;
        @(negedge clk); start = 1'b0; a = ~x; b = ~y; op = ~o;
        check("R9 busy", {31'b0, busy}, 32'd1);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k < lat) check({lt, " early done"}, {31'b0, done}, 32'd0);
            else begin
                check({lt, " done"}, {31'b0, done}, 32'd1);
                check({rtag(o), " result"}, result, model(o, x, y));
            end
        end
        @(negedge clk);
        check("R8 pulse", {31'b0, done}, 32'd0);
    endtask

    task automatic t_ignore();
        logic [31:0] x = 32'hDEADBEEF, y = 32'h12345678;
        @(negedge clk); op = 2'd3; a = x; b = y; start = 1'b1;
        @(negedge clk); op = 2'd0; a = 32'd7; b = 32'd9;   // busy: must be ignored
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check("R9 no early done", {31'b0, done}, 32'd0);
        @(negedge clk);
        check("R9 done on time", {31'b0, done}, 32'd1);
        check("R9 result kept", result, model(2'd3, x, y));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9 no extra done", {31'b0, done}, 32'd0);
        end
        check("R9 result after", result, model(2'd3, x, y));
    endtask

    task automatic t_back2back();
        logic [31:0] x1 = 32'hFFFF0001, y1 = 32'h0000FFFF;
        logic [31:0] x2 = 32'h80000001, y2 = 32'hFFFFFFFE;
        @(negedge clk); op = 2'd0; a = x1; b = y1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 first done", {31'b0, done}, 32'd1);
        check("R10 first result", result, model(2'd0, x1, y1));
        op = 2'd2; a = x2; b = y2; start = 1'b1;   // same cycle as done
        @(negedge clk); start = 1'b0;
        check("R10 busy again", {31'b0, busy}, 32'd1);
        check("R10 done dropped", {31'b0, done}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        check("R10 hold between", result, model(2'd0, x1, y1));
        check("R10 not yet", {31'b0, done}, 32'd0);
        @(negedge clk);
        check("R10 second done", {31'b0, done}, 32'd1);
        check("R10 second result", result, model(2'd2, x2, y2));
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        t_op(2'd1, 32'h00000123, 32'hFFFFF000);
        keep = result;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); a = 32'h1111 * k; b = ~a; op = k[1:0];
            check("R11 hold", result, keep);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_op(2'd0, 32'd3, 32'd5);
        t_op(2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        t_op(2'd0, 32'h12345678, 32'h9ABCDEF0);
        t_op(2'd1, 32'h80000000, 32'h80000000);
        t_op(2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF);
        t_op(2'd1, 32'h7FFFFFFF, 32'h80000000);
        t_op(2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);
        t_op(2'd2, 32'h80000000, 32'hFFFFFFFF);
        t_op(2'd2, 32'h00000005, 32'h80000000);
        t_op(2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF);
        t_op(2'd3, 32'hDEADBEEF, 32'h12345678);
        t_op(2'd3, 32'h00000000, 32'hFFFFFFFF);
        t_ignore();
        t_back2back();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule